// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag side of a 32 KB level-one cache built from 32-byte lines in 4-way sets, addressed by 32-bit byte addresses. It takes one processor access at a time, reads or writes. It compares the access against the stored tags of the selected set and reports a hit or a miss. It also keeps free-running hit and miss totals. Line storage itself is not modelled. The block holds only the tag, valid flag, dirty flag and age of each way, and it issues the line fills, evictions and write-throughs that the missing data path would need.

A static mode input selects the write policy. With `wb_mode` low, writes go straight through to memory and a write miss leaves the cache unchanged. With `wb_mode` high, a write miss first fetches the line, and every write then stays in the cache and marks the line dirty. A dirty line is written back to memory when it is evicted. Memory traffic uses a valid/ready handshake. While such a transaction is outstanding, `busy` is high and new processor requests are not taken.

Top module: `l1_tag_ctrl`

## Requirements
- R1: The byte address splits into offset bits [4:0], set index bits [12:5] (256 sets) and tag bits [31:13]. Two addresses in the same line hit each other. Addresses that differ in the index are looked up in different sets.
- R2: A miss that allocates raises `mem_req_valid` with `mem_req_write`=0 and `mem_req_addr` equal to the line address (the access address with bits [4:0] cleared). After the handshake the line is valid, and the next access to it hits.
- R3: With `wb_mode`=0, every write, hit or miss, issues exactly one memory transaction with `mem_req_write`=1 carrying the full access address. A write miss does not allocate, so a following read of that line misses.
- R4: With `wb_mode`=1, a write hit issues no memory transaction. A write miss fetches the line with one fill and installs it dirty.
- R5: With `wb_mode`=1, replacing a dirty line first issues a write transaction (`mem_req_write`=1) to the victim's line address and then the fill. Replacing a clean or invalid way issues the fill alone.
- R6: The victim is the lowest-numbered invalid way of the set if one exists. Otherwise it is the least recently used way. Recency is updated by every hit and every fill.
- R7: `mem_req_valid`, `mem_req_addr` and `mem_req_write` hold steady until `mem_req_ready` is seen. `busy` is high whenever a memory transaction is pending. A request presented while `busy` is high is ignored.
- R8: Each accepted request (`req_valid` high while `busy` low) increments exactly one of `hit_count` and `miss_count`. Its completion produces a one-cycle `resp_valid` with `resp_hit`. On a hit that needs no memory traffic this is the cycle after acceptance. Otherwise it is the cycle after the last handshake.
- R9: A synchronous reset (`rst` high at a clock edge) invalidates every way, clears all dirty flags, restores the age order, zeroes both counters and leaves `busy`, `mem_req_valid` and `resp_valid` low.
- R10: From reset, the access sequence RD 0x00000000, WR 0x01000000, RD 0x01000010, WR 0x02000050, RD 0x02000058 gives 5 misses and 0 hits with `wb_mode`=0. With `wb_mode`=1 it gives 3 misses and 2 hits, the hits being 0x01000010 and 0x02000058.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wb_mode | input | 1 | Write policy: 1 write-back with allocate, 0 write-through without allocate |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Request byte address |
| busy | output | 1 | Controller waiting on memory; requests not taken |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Completed request was a hit |
| hit_count | output | 32 | Total hits since reset |
| miss_count | output | 32 | Total misses since reset |
| mem_req_valid | output | 1 | Memory transaction requested |
| mem_req_write | output | 1 | 1 write (eviction or write-through), 0 line fill |
| mem_req_addr | output | 32 | Memory transaction address |
| mem_req_ready | input | 1 | Memory accepts and completes the transaction |

## Verification
A stale valid flag or tag shows up only on the next access to that set, as a wrong `resp_hit` one cycle after acceptance. A lost or spurious dirty flag stays hidden until that way is chosen as victim, and then shows as a missing or extra eviction write ahead of the fill. Corrupted age state is the slowest to appear: it needs at least five distinct tags in one set before a wrong line is dropped. The bench therefore fills a set past its capacity and reads back which tags survive.

// File: rtl/l1_tag_ctrl.sv
module l1_tag_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 8,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready
);
  localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
  localparam int SETS  = 1 << INDEX_W;
  localparam int WAY_W = $clog2(WAYS);

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_WRITE} state_t;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic             valid_q [SETS][WAYS];
  logic             dirty_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];

  state_t            state_q;
  logic [ADDR_W-1:0] r_addr;
  logic              r_write, r_hit;
  logic [WAY_W-1:0]  r_way;
  logic [TAG_W-1:0]  r_vtag;
  logic [CNT_W-1:0]  hit_q, miss_q;

  wire [INDEX_W-1:0] lk_set = req_addr[OFFSET_W +: INDEX_W];
  wire [TAG_W-1:0]   lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [INDEX_W-1:0] r_set  = r_addr[OFFSET_W +: INDEX_W];
  wire [TAG_W-1:0]   r_tag  = r_addr[ADDR_W-1 -: TAG_W];

  wire accept    = (state_q == S_IDLE) && req_valid;
  wire fill_done = (state_q == S_FILL) && mem_req_ready;

  logic             hit_any;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic             vic_evict;

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    vic_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (age_q[lk_set][w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_q[lk_set][w]) vic_way = WAY_W'(w);
    vic_evict = wb_mode && valid_q[lk_set][vic_way] && dirty_q[lk_set][vic_way];
  end

  wire              touch_en  = (accept && hit_any) || fill_done;
  wire [INDEX_W-1:0] touch_set = fill_done ? r_set : lk_set;
  wire [WAY_W-1:0]  touch_way = fill_done ? r_way : hit_way;
  logic [WAY_W-1:0] new_age [WAYS];

  always_comb begin
    for (int j = 0; j < WAYS; j++) begin
      if (WAY_W'(j) == touch_way)
        new_age[j] = '0;
      else if (age_q[touch_set][j] < age_q[touch_set][touch_way])
        new_age[j] = age_q[touch_set][j] + 1'b1;
      else
        new_age[j] = age_q[touch_set][j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          dirty_q[s][w] <= 1'b0;
          age_q[s][w]   <= WAY_W'(w);
        end
    end else begin
      if (touch_en)
        for (int j = 0; j < WAYS; j++) age_q[touch_set][j] <= new_age[j];
      if (accept && hit_any && req_write && wb_mode)
        dirty_q[lk_set][hit_way] <= 1'b1;
      if (fill_done) begin
        tag_q[r_set][r_way]   <= r_tag;
        valid_q[r_set][r_way] <= 1'b1;
        dirty_q[r_set][r_way] <= wb_mode && r_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      hit_q      <= '0;
      miss_q     <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      r_addr     <= '0;
      r_write    <= 1'b0;
      r_hit      <= 1'b0;
      r_way      <= '0;
      r_vtag     <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          r_addr  <= req_addr;
          r_write <= req_write;
          r_hit   <= hit_any;
          r_way   <= hit_any ? hit_way : vic_way;
          r_vtag  <= tag_q[lk_set][vic_way];
          if (hit_any) begin
            hit_q <= hit_q + 1'b1;
            if (req_write && !wb_mode) state_q <= S_WRITE;
            else begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
            end
          end else begin
            miss_q <= miss_q + 1'b1;
            if (req_write && !wb_mode) state_q <= S_WRITE;
            else if (vic_evict)        state_q <= S_EVICT;
            else                       state_q <= S_FILL;
          end
        end
        S_EVICT: if (mem_req_ready) state_q <= S_FILL;
        S_FILL: if (mem_req_ready) begin
          state_q    <= S_IDLE;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
        end
        S_WRITE: if (mem_req_ready) begin
          state_q    <= S_IDLE;
          resp_valid <= 1'b1;
          resp_hit   <= r_hit;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != S_IDLE);
  assign mem_req_valid = busy;
  assign mem_req_write = (state_q == S_EVICT) || (state_q == S_WRITE);
  assign hit_count     = hit_q;
  assign miss_count    = miss_q;

  always_comb begin
    case (state_q)
      S_EVICT: mem_req_addr = {r_vtag, r_set, {OFFSET_W{1'b0}}};
      S_FILL:  mem_req_addr = {r_tag, r_set, {OFFSET_W{1'b0}}};
      S_WRITE: mem_req_addr = r_addr;
      default: mem_req_addr = '0;
    endcase
  end
endmodule

// File: rtl/l1_tag_ctrl_chk.sv
module l1_tag_ctrl_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int CNT_W    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_mode,
  input logic              req_valid,
  input logic              busy,
  input logic              resp_valid,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_ready
);
  wire [CNT_W:0] total = {1'b0, hit_count} + {1'b0, miss_count};

  // R7: pending memory traffic always shows as busy
  a_r7_busy_covers_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);

  // R7: request held until accepted
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R8: one counter step per accepted request
  a_r8_one_count: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy |=> total == $past(total) + 1'b1);

  // R7, R8: no counting while busy or idle
  a_r7_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !busy) |=> $stable(total));

  // R2: fills are line aligned
  a_r2_fill_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_write |-> mem_req_addr[OFFSET_W-1:0] == '0);

  // R5: write-back mode writes are whole-line evictions
  a_r5_evict_aligned: assert property (@(posedge clk) disable iff (rst)
    wb_mode && mem_req_valid && mem_req_write |-> mem_req_addr[OFFSET_W-1:0] == '0);

  // R9: reset leaves everything quiet and zeroed
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !busy && !resp_valid && hit_count == '0 && miss_count == '0);
endmodule

bind l1_tag_ctrl l1_tag_ctrl_chk #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wb_mode(wb_mode), .req_valid(req_valid), .busy(busy),
  .resp_valid(resp_valid), .hit_count(hit_count), .miss_count(miss_count),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready));

// File: tb/l1_tag_ctrl_tb_top.sv
module l1_tag_ctrl_tb_top;
  logic        clk = 0, rst = 1, wb_mode = 0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic        busy, resp_valid, resp_hit, mem_req_valid, mem_req_write;
  logic        mem_req_ready = 0;
  logic [31:0] hit_count, miss_count, mem_req_addr;

  always #10 clk = ~clk;

  l1_tag_ctrl dut_i (
    .clk(clk), .rst(rst), .wb_mode(wb_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .busy(busy),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .hit_count(hit_count),
    .miss_count(miss_count), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // memory responder with logging
  int          lat = 0, wcnt = 0, mem_cnt = 0;
  logic        log_w [64];
  logic [31:0] log_a [64];
  always @(negedge clk) begin
    if (mem_req_ready) mem_req_ready = 0;
    else if (mem_req_valid) begin
      if (wcnt >= lat) begin
        mem_req_ready = 1;
        log_w[mem_cnt % 64] = mem_req_write;
        log_a[mem_cnt % 64] = mem_req_addr;
        mem_cnt++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    wb_mode = mode; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  int first_log;
  task automatic access(input logic wr, input logic [31:0] a, output logic hit, output int nmem);
    int guard;
    @(negedge clk);
    while (busy) @(negedge clk);
    first_log = mem_cnt;
    req_valid = 1; req_write = wr; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    while (!resp_valid && guard < 1000) begin @(negedge clk); guard++; end
    if (guard >= 1000) chk("R8 response timeout", 0, 1);
    hit = resp_hit;
    nmem = mem_cnt - first_log;
  endtask

  // {reset_before, mode, write, exp_hit, exp_nmem[1:0], addr[31:0]}
  localparam logic [37:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0100_0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0100_0010},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0200_0050},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0200_0058},
    {1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0000_0000},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 32'h0100_0000},
    {1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0100_0010},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 32'h0200_0050},
    {1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0200_0058}
  };

  function automatic logic [31:0] s3(input int t);
    return 32'(t) * 32'h2000 + 32'h60;
  endfunction

  initial begin
    logic h; int n; logic [31:0] held;
    do_reset(0);
    // R9 reset state
    @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 mem_req_valid", mem_req_valid, 0);
    chk("R9 resp_valid", resp_valid, 0);
    chk("R9 counters", {hit_count, miss_count}, 0);

    // R10 vector table
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][37]) do_reset(VEC[i][36]);
      access(VEC[i][35], VEC[i][31:0], h, n);
      chk($sformatf("R10 hit vec %0d", i), h, VEC[i][34]);
      chk($sformatf("R10 mem count vec %0d", i), n, VEC[i][33:32]);
      if (i == 4) chk("R10 write-through totals", {hit_count, miss_count}, {32'd0, 32'd5});
      if (i == 9) chk("R10 write-back totals", {hit_count, miss_count}, {32'd2, 32'd3});
    end

    // R1, R2
    do_reset(1);
    access(0, 32'h1234_5678, h, n);
    chk("R2 fill miss", h, 0);
    chk("R2 one fill", n, 1);
    chk("R2 fill is read", log_w[first_log % 64], 0);
    chk("R2 fill line address", log_a[first_log % 64], 32'h1234_5660);
    access(0, 32'h1234_567C, h, n);
    chk("R1 same line hits", h, 1);
    access(0, 32'h1234_5698, h, n);
    chk("R1 other index misses", h, 0);

    // R3
    do_reset(0);
    access(0, 32'h0000_0040, h, n);
    access(1, 32'h0000_0044, h, n);
    chk("R3 write hit", h, 1);
    chk("R3 write hit mem count", n, 1);
    chk("R3 write-through kind", log_w[first_log % 64], 1);
    chk("R3 write-through address", log_a[first_log % 64], 32'h0000_0044);
    access(1, 32'h0040_0000, h, n);
    chk("R3 write miss mem count", n, 1);
    access(0, 32'h0040_0000, h, n);
    chk("R3 no allocate on write miss", h, 0);

    // R4
    do_reset(1);
    access(0, 32'h0000_0080, h, n);
    access(1, 32'h0000_0084, h, n);
    chk("R4 write hit", h, 1);
    chk("R4 write hit no traffic", n, 0);
    access(1, 32'h0080_0080, h, n);
    chk("R4 write miss one fill", n, 1);
    chk("R4 write miss fill is read", log_w[first_log % 64], 0);
    access(0, 32'h0080_0080, h, n);
    chk("R4 allocated line hits", h, 1);

    // R5, R6 on set 3
    do_reset(1);
    for (int t = 1; t <= 4; t++) begin
      access(0, s3(t), h, n);
      chk($sformatf("R6 invalid way used, tag %0d", t), n, 1);
    end
    access(1, s3(2), h, n);
    chk("R4 dirty write hit", h, 1);
    access(0, s3(1), h, n);
    chk("R6 touch tag 1", h, 1);
    access(0, s3(5), h, n);
    chk("R5 clean victim no write-back", n, 1);
    access(0, s3(6), h, n);
    chk("R5 clean victim no write-back 2", n, 1);
    access(0, s3(7), h, n);
    chk("R5 dirty victim two transactions", n, 2);
    chk("R5 write-back first", log_w[first_log % 64], 1);
    chk("R5 write-back victim address", log_a[first_log % 64], s3(2));
    chk("R5 fill second", log_w[(first_log + 1) % 64], 0);
    chk("R5 fill address", log_a[(first_log + 1) % 64], s3(7));
    access(0, s3(1), h, n);
    chk("R6 recently used line kept", h, 1);
    access(0, s3(3), h, n);
    chk("R6 least recent line evicted", h, 0);

    // R7 slow memory, request ignored while busy
    do_reset(1);
    lat = 3;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 32'h0000_1000;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'h0000_2000;
    chk("R7 busy during fill", busy, 1);
    chk("R7 valid raised", mem_req_valid, 1);
    held = mem_req_addr;
    @(negedge clk);
    chk("R7 valid held", mem_req_valid, 1);
    chk("R7 address held", mem_req_addr, held);
    req_valid = 0;
    while (!resp_valid) @(negedge clk);
    chk("R7 ignored request not counted", miss_count, 1);
    lat = 0;
    access(0, 32'h0000_2000, h, n);
    chk("R7 ignored request not installed", h, 0);
    access(0, 32'h0000_1000, h, n);
    chk("R8 slow fill installed", h, 1);

    // R9 reset mid-run
    do_reset(1);
    @(negedge clk);
    chk("R9 counters cleared", {hit_count, miss_count}, 0);
    access(0, 32'h0000_1000, h, n);
    chk("R9 lines invalidated", h, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule